// File: doc/BRIEF.md
# Single-Bank DRAM Command Spacing Guard

This block follows the state of one DRAM bank and decides, on every memory clock, which commands the bank may legally receive next. A controller presents one-cycle strobes for activate, read, write and precharge. The block answers with three permission flags: one for activate, one shared by read and write, and one for precharge. Each flag rises only after the programmed same-bank gap has elapsed since the command it depends on.

The gap lengths come from a 32-bit configuration word. The word is captured on a load strobe, and each field is clamped into its legal range when it is captured. For every accepted read, the block also produces a one-cycle read-data-valid strobe after the CAS latency. This strobe models only the data delay. The point at which the physical interface samples the data is handled elsewhere.

A command issued while its permission flag is low is refused and does not change the bank state. The same applies when more than one strobe is raised in the same cycle. In both cases a violation flag is set and stays set until reset.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset the bank is closed, act_ok=1, rdwr_ok=0, pre_ok=0, rd_valid=0 and violation=0. The activate-to-column gap, precharge-to-activate gap, CAS latency and write recovery all hold 6.
- R2: After an accepted activate sampled at clock edge e, rdwr_ok is low until edge e+tRCD-1 and is high from then on, so a read or write is first accepted at edge e+tRCD.
- R3: After an accepted precharge sampled at edge e, the bank is closed and act_ok first becomes high after edge e+tRP-1.
- R4: A read accepted at edge e makes rd_valid high for exactly the one cycle between edges e+tCL-1 and e+tCL. Back-to-back reads give back-to-back strobes.
- R5: After an accepted write sampled at edge e, pre_ok stays low until edge e+4+tWR-1, where 4 is the fixed burst length. Reads place no delay on precharge.
- R6: On a load, the fields are cfg_word[3:0]=tRCD, [7:4]=tRP, [11:8]=tCL and [16:12]=tWR. tRCD and tRP are clamped to 4..15, tCL to 5..15 and tWR to 5..16. Bits 31:17 are ignored.
- R7: A strobe whose permission flag is low sets violation, which then stays high until reset. The refused command changes neither the bank state nor the counters, and produces no rd_valid.
- R8: Two or more strobes in the same cycle set violation, and none of those commands is accepted.
- R9: A new configuration applies only to commands sampled after the load edge. A gap that is already counting keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture cfg_word on this edge |
| cfg_word | input | 32 | Packed timing fields |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_pre | input | 1 | Precharge strobe |
| act_ok | output | 1 | Activate may be issued |
| rdwr_ok | output | 1 | Read or write may be issued |
| pre_ok | output | 1 | Precharge may be issued |
| rd_valid | output | 1 | Read data due this cycle |
| violation | output | 1 | Sticky illegal-command flag |

## Verification
A permission flag depends on a counter that is loaded at the edge sampling the command. The bench therefore expects the flag to be low at each falling edge for the first N-1 cycles and high at the falling edge after edge e+N-1. It checks every one of those cycles, not just the end point. Read-valid timing is handled by a scoreboard. The driver queues the cycle number cyc+tCL at the moment it drives a read, and a monitor compares rd_valid against the head of that queue at every falling edge. This catches both a strobe that arrives late and one that arrives unexpectedly. Refused commands are checked by observing that the permission flags keep their values and that no read-valid strobe is produced.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

  typedef struct packed {
    logic [4:0] twr;
    logic [3:0] tcl;
    logic [3:0] trp;
    logic [3:0] trcd;
  } bt_cfg_t;

  function automatic logic [3:0] clamp_lo4(input logic [3:0] v, input logic [3:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic logic [4:0] clamp5(input logic [4:0] v, input logic [4:0] lo,
                                        input logic [4:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/bt_cfg_reg.sv
module bt_cfg_reg
  import bank_timing_pkg::*;
#(
  parameter logic [3:0] DEF_T = 4'd6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [16:0]   word,
  output bt_cfg_t       cfg
);

  bt_cfg_t nxt;

  always_comb begin
    nxt.trcd = clamp_lo4(word[3:0], 4'd4);
    nxt.trp  = clamp_lo4(word[7:4], 4'd4);
    nxt.tcl  = clamp_lo4(word[11:8], 4'd5);
    nxt.twr  = clamp5(word[16:12], 5'd5, 5'd16);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.trcd <= DEF_T;
      cfg.trp  <= DEF_T;
      cfg.tcl  <= DEF_T;
      cfg.twr  <= {1'b0, DEF_T};
    end else if (load) begin
      cfg <= nxt;
    end
  end

  // R6
  cfg_range_chk: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (cfg.trcd >= 4'd4 && cfg.trp >= 4'd4 && cfg.tcl >= 4'd5 &&
                     cfg.twr >= 5'd5 && cfg.twr <= 5'd16));

endmodule

// File: rtl/bt_gap_counter.sv
module bt_gap_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R2 R3 R5: a freshly started gap is never already expired
  gap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (load && val != '0) |=> !done);

endmodule

// File: rtl/bt_read_pipe.sv
module bt_read_pipe #(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [IW-1:0] lat,
  output logic          valid
);

  logic [DEPTH-1:0] pipe, nxt;

  always_comb begin
    nxt = pipe >> 1;
    if (fire) nxt[lat - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= nxt;
  end

  assign valid = pipe[0];

  // R4: no strobe appears without a read issued earlier
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe == '0 && !fire) |=> !valid);

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_timing_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 5,
  parameter int PIPE_D    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_load,
  input  logic [31:0] cfg_word,
  input  logic        cmd_act,
  input  logic        cmd_rd,
  input  logic        cmd_wr,
  input  logic        cmd_pre,
  output logic        act_ok,
  output logic        rdwr_ok,
  output logic        pre_ok,
  output logic        rd_valid,
  output logic        violation
);

  localparam int PIPE_IW = $clog2(PIPE_D);

  bt_cfg_t cfg;
  logic    unused_hi;
  logic    multi, act_go, rd_go, wr_go, pre_go, bad;
  logic    bank_open, rcd_done, rp_done, wrr_done;

  assign unused_hi = ^cfg_word[31:17];

  bt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load), .word(cfg_word[16:0]), .cfg(cfg)
  );

  assign multi  = ($countones({cmd_act, cmd_rd, cmd_wr, cmd_pre}) > 1);
  assign act_ok  = !bank_open && rp_done;
  assign rdwr_ok = bank_open && rcd_done;
  assign pre_ok  = bank_open && wrr_done;

  assign act_go = cmd_act && !multi && act_ok;
  assign rd_go  = cmd_rd  && !multi && rdwr_ok;
  assign wr_go  = cmd_wr  && !multi && rdwr_ok;
  assign pre_go = cmd_pre && !multi && pre_ok;
  assign bad    = multi || (cmd_act && !act_ok) || ((cmd_rd || cmd_wr) && !rdwr_ok) ||
                  (cmd_pre && !pre_ok);

  bt_gap_counter #(.W(CNT_W)) u_rcd (
    .clk(clk), .rst(rst), .load(act_go),
    .val(CNT_W'(cfg.trcd) - 1'b1), .done(rcd_done)
  );

  bt_gap_counter #(.W(CNT_W)) u_rp (
    .clk(clk), .rst(rst), .load(pre_go),
    .val(CNT_W'(cfg.trp) - 1'b1), .done(rp_done)
  );

  bt_gap_counter #(.W(CNT_W)) u_wrr (
    .clk(clk), .rst(rst), .load(wr_go),
    .val(CNT_W'(cfg.twr) + CNT_W'(BURST_LEN) - 1'b1), .done(wrr_done)
  );

  bt_read_pipe #(.DEPTH(PIPE_D)) u_pipe (
    .clk(clk), .rst(rst), .fire(rd_go), .lat(cfg.tcl[PIPE_IW-1:0]), .valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= 1'b0;
      violation <= 1'b0;
    end else begin
      if (act_go)      bank_open <= 1'b1;
      else if (pre_go) bank_open <= 1'b0;
      if (bad)         violation <= 1'b1;
    end
  end

  // R7
  sticky_viol_chk: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

  // R8
  multi_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    multi |=> ($stable(bank_open) && violation));

  // R5
  wr_blocks_pre_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !pre_ok);

  // R3
  pre_closes_chk: assert property (@(posedge clk) disable iff (rst)
    pre_go |=> (!bank_open && !act_ok));

endmodule

// File: tb/test_bank_timing_guard.sv
module test_bank_timing_guard;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic ca = 1'b0, cr = 1'b0, cw = 1'b0, cp = 1'b0;
  logic act_ok, rdwr_ok, pre_ok, rd_valid, violation;
  int cyc = 0, checks = 0, failures = 0;
  int exp_q[$];
  bit mon_e;

  bank_timing_guard i_bank_timing_guard (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .cmd_act(ca), .cmd_rd(cr), .cmd_wr(cw), .cmd_pre(cp),
    .act_ok(act_ok), .rdwr_ok(rdwr_ok), .pre_ok(pre_ok),
    .rd_valid(rd_valid), .violation(violation)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: scoreboard for read-valid strobes (R4)
  always @(negedge clk) begin
    if (!rst) begin
      mon_e = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (mon_e) void'(exp_q.pop_front());
      chk(rd_valid == mon_e, "R4 rd_valid", int'(rd_valid), int'(mon_e));
    end
  end

  function automatic logic flag(input int w);
    case (w)
      0:       return act_ok;
      1:       return rdwr_ok;
      default: return pre_ok;
    endcase
  endfunction

  // driver: one-cycle strobes; cl>0 queues the expected read-valid cycle
  task automatic issue(input bit a, input bit r, input bit w, input bit p, input int cl);
    ca = a; cr = r; cw = w; cp = p;
    if (cl > 0) exp_q.push_back(cyc + cl);
    @(negedge clk);
    ca = 0; cr = 0; cw = 0; cp = 0;
  endtask

  task automatic load(input logic [31:0] wd);
    cfg_word = wd; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic gap(input int w, input int n, input string tag);
    for (int i = 1; i < n; i++) begin
      chk(flag(w) == 1'b0, tag, int'(flag(w)), 0);
      @(negedge clk);
    end
    chk(flag(w) == 1'b1, tag, int'(flag(w)), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_state_check();
    chk(act_ok == 1'b1,    "R1 act_ok",    int'(act_ok), 1);
    chk(rdwr_ok == 1'b0,   "R1 rdwr_ok",   int'(rdwr_ok), 0);
    chk(pre_ok == 1'b0,    "R1 pre_ok",    int'(pre_ok), 0);
    chk(violation == 1'b0, "R1 violation", int'(violation), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    reset_state_check();

    // defaults of 6
    issue(1, 0, 0, 0, 0);
    gap(1, 6, "R2 default tRCD");
    issue(0, 1, 0, 0, 6);
    chk(pre_ok == 1'b1, "R5 read no pre delay", int'(pre_ok), 1);
    issue(0, 1, 0, 0, 6);
    idle(8);
    issue(0, 0, 0, 1, 0);
    gap(0, 6, "R3 default tRP");

    // twr=16 tcl=15 trp=15 trcd=8
    load(32'h0001_0FF8);
    issue(1, 0, 0, 0, 0);
    gap(1, 8, "R2 tRCD=8");
    issue(0, 1, 0, 0, 15);
    idle(17);
    issue(0, 0, 0, 1, 0);
    gap(0, 15, "R3 tRP=15");

    // load during a running gap; new word clamps to trcd4 trp4 tcl5 twr16
    issue(1, 0, 0, 0, 0);
    load(32'hABC1_F230);
    gap(1, 7, "R9 running gap keeps old tRCD");
    issue(0, 0, 1, 0, 0);
    gap(2, 20, "R5 R6 write recovery 4+16");
    issue(0, 1, 0, 0, 5);
    idle(7);
    issue(0, 0, 0, 1, 0);
    gap(0, 4, "R6 tRP clamp");
    issue(1, 0, 0, 0, 0);
    gap(1, 4, "R6 tRCD clamp");

    // refused activate on an open bank
    issue(1, 0, 0, 0, 0);
    chk(violation == 1'b1, "R7 violation set", int'(violation), 1);
    chk(rdwr_ok == 1'b1,   "R7 refused ACT no reload", int'(rdwr_ok), 1);
    issue(0, 0, 0, 1, 0);
    gap(0, 4, "R7 state after refusal");
    issue(0, 1, 0, 0, 0);
    chk(rdwr_ok == 1'b0,   "R7 bank stays closed", int'(rdwr_ok), 0);
    idle(8);
    chk(violation == 1'b1, "R7 sticky", int'(violation), 1);

    // reset restores defaults, then simultaneous strobes
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    reset_state_check();
    issue(1, 1, 0, 0, 0);
    chk(violation == 1'b1, "R8 violation", int'(violation), 1);
    chk(act_ok == 1'b1,    "R8 act ignored", int'(act_ok), 1);
    chk(rdwr_ok == 1'b0,   "R8 rd ignored", int'(rdwr_ok), 0);
    issue(1, 0, 0, 0, 0);
    gap(1, 6, "R1 default tRCD after reset");
    issue(0, 1, 0, 0, 6);
    idle(8);
    chk(exp_q.size() == 0, "R4 all strobes seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule